// File: doc/BRIEF.md
# Streaming Depthwise 3x3 Convolution Stage

This block is one stage of a layer-pipelined convolutional network accelerator. It takes a feature map as a stream in raster order. Each pixel arrives as one or more beats, and each beat carries a group of `N_IO` channels. All channel groups of a pixel come before the next pixel. Every channel is filtered by its own 3x3 kernel with stride 1, and zero padding keeps the output frame at the input size. The nine products of each channel are summed, scaled down by a fixed arithmetic right shift, clamped to the unsigned 8-bit range and sent out. The clamp at zero acts as a plain ReLU. The output stream uses the same beat and group order as the input.

Two line buffers hold the two previous rows, one entry per column and channel group, so every input beat is read from the stream exactly once. A short column chain supplies the two previous columns of the current group. The kernels sit in a small weight store. The store has one word per kernel tap and group, and each word packs the `N_IO` channel weights side by side. It is written through a simple write port before a frame starts.

Both stream edges use valid/ready handshakes. When the consumer holds back, the whole stage stops, including the line-buffer writes, and no data is lost.

Top module: `dwconv3x3_stream`

## Requirements
- R1: Input and output beats carry `N_IO` unsigned 8-bit channels, with channel j of the beat at bits [8j+7:8j]. Group g of a beat holds channels g*N_IO..g*N_IO+N_IO-1. Beats are ordered by row, then column, then group. A frame yields exactly IMG_W*IMG_H*(CHANNELS/N_IO) output beats in that same order.
- R2: Output channel ch at pixel (r,c) is the sum over dy,dx in {-1,0,1} of in(r+dy,c+dx,ch)*w(ch,(dy+1)*3+(dx+1)). Positions outside the frame contribute zero.
- R3: Weight word address g*9+tap holds the kernels of group g. Channel j's weight is at bits [5j+4:5j] as 5-bit two's complement. A word is stored on a rising clock edge while `wt_we` is high.
- R4: Each output channel is the signed sum shifted right arithmetically by SHIFT and clamped to 0..255. Negative results become 0, and results above 255 become 255.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` holds its value and `in_ready` is low.
- R6: From a frame start, the first output beat becomes valid in the cycle after the ((IMG_W+1)*(CHANNELS/N_IO)+1)-th input beat of the frame is accepted.
- R7: After the last input beat of a frame, the remaining outputs come out with no further input. The stage then returns to row 0, column 0, group 0, with `in_ready` high and `out_valid` low, ready for the next frame.
- R8: While reset is asserted and right after it, `out_valid` is low and `in_ready` is high, at the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wt_we | input | 1 | Weight word write strobe |
| wt_addr | input | $clog2(9*CHANNELS/N_IO) | Weight word address, group*9+tap |
| wt_data | input | 5*N_IO | Packed channel weights for one tap |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage accepts the input beat |
| in_data | input | 8*N_IO | Input beat, N_IO channels |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_data | output | 8*N_IO | Output beat, N_IO channels |

## Verification
An output beat is registered once, in the cycle after the scan slot that completes its window. That slot is the input beat one row below and one column right of the pixel, or an internal padding slot at the right or bottom edge. The first output of a frame is therefore due one cycle after input beat (IMG_W+1)*(CHANNELS/N_IO)+1.

The bench drives inputs at the falling edge and samples one time unit later. Each result is seen in the half cycle before the edge that transfers it. It compares the value only on cycles where `out_valid` and `out_ready` are both high, against a model of the frame computed in the bench. Because of that, gaps on either side move results in time without changing what is expected. Held outputs are compared with the value from the previous cycle.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int ACT_W  = 8;
  localparam int WT_W   = 5;
  localparam int TAPS   = 9;
  localparam int PROD_W = ACT_W + WT_W;
  localparam int SUM_W  = PROD_W + 4;
  localparam logic signed [SUM_W-1:0] ACT_MAX = SUM_W'((1 << ACT_W) - 1);

  // unsigned activation times signed weight, exact in PROD_W bits
  function automatic logic signed [PROD_W-1:0] tap_product(
    input logic [ACT_W-1:0] a,
    input logic [WT_W-1:0]  w
  );
    logic signed [PROD_W-1:0] ax;
    logic signed [PROD_W-1:0] wx;
    ax = signed'({{(PROD_W-ACT_W){1'b0}}, a});
    wx = signed'({{(PROD_W-WT_W){w[WT_W-1]}}, w});
    return ax * wx;
  endfunction

  // arithmetic shift, then ReLU and upper saturation
  function automatic logic [ACT_W-1:0] requant(
    input logic signed [SUM_W-1:0] s,
    input int                      sh
  );
    logic signed [SUM_W-1:0] t;
    t = s >>> sh;
    if (t[SUM_W-1]) return '0;
    if (t > ACT_MAX) return '1;
    return t[ACT_W-1:0];
  endfunction
endpackage

// File: rtl/dwc_scan.sv
module dwc_scan #(
  parameter int IMG_W  = 8,
  parameter int IMG_H  = 6,
  parameter int GROUPS = 2,
  localparam int COL_W = $clog2(IMG_W + 1),
  localparam int ROW_W = $clog2(IMG_H + 1),
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic [GRP_W-1:0] grp,
  output logic             needs_in,
  output logic             emits
);
  logic grp_last, col_last, row_last, frame_wrap;

  assign grp_last   = (grp == GRP_W'(GROUPS - 1));
  assign col_last   = (col == COL_W'(IMG_W));
  assign row_last   = (row == ROW_W'(IMG_H));
  assign frame_wrap = go && grp_last && col_last && row_last;

  // slot grid is (IMG_H+1) x (IMG_W+1) x GROUPS; last row/column are padding
  assign needs_in = (col != COL_W'(IMG_W)) && (row != ROW_W'(IMG_H));
  assign emits    = (col != '0) && (row != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      grp <= '0;
    end else if (go) begin
      if (grp_last) begin
        grp <= '0;
        if (col_last) begin
          col <= '0;
          row <= row_last ? '0 : row + ROW_W'(1);
        end else begin
          col <= col + COL_W'(1);
        end
      end else begin
        grp <= grp + GRP_W'(1);
      end
    end
  end

  p_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col <= COL_W'(IMG_W)) && (row <= ROW_W'(IMG_H)) && (grp <= GRP_W'(GROUPS - 1)));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (row == '0) && (col == '0) && (grp == '0));
endmodule

// File: rtl/dwc_window.sv
module dwc_window import dwc_pkg::*; #(
  parameter int IMG_W  = 8,
  parameter int GROUPS = 2,
  parameter int N_IO   = 4,
  localparam int BEAT_W = N_IO * ACT_W,
  localparam int COL_W  = $clog2(IMG_W + 1),
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int DEPTH  = IMG_W * GROUPS,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CV_W   = 3 * BEAT_W,
  localparam int CHAIN  = 2 * GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [COL_W-1:0]  col,
  input  logic [GRP_W-1:0]  grp,
  input  logic              top_zero,
  input  logic              mid_zero,
  input  logic              left_zero,
  input  logic              right_pad,
  input  logic [BEAT_W-1:0] pix_in,
  output logic [BEAT_W-1:0] win [TAPS]
);
  logic [BEAT_W-1:0] lb_near [DEPTH];
  logic [BEAT_W-1:0] lb_far  [DEPTH];
  logic [CV_W-1:0]   chain   [CHAIN];
  logic [CV_W-1:0]   cols    [3];
  logic [CV_W-1:0]   cur_col;
  logic [BEAT_W-1:0] up2, up1;
  logic [AW-1:0]     addr;
  logic              lb_wr;
  int                lin;

  assign lin   = int'(col) * GROUPS + int'(grp);
  assign addr  = right_pad ? '0 : AW'(lin);
  assign lb_wr = go && !right_pad;

  // column vector {row-2, row-1, row} for the current slot
  assign up2     = (top_zero || right_pad) ? '0 : lb_far[addr];
  assign up1     = (mid_zero || right_pad) ? '0 : lb_near[addr];
  assign cur_col = {up2, up1, right_pad ? '0 : pix_in};

  always_ff @(posedge clk) begin
    if (lb_wr) begin
      lb_far[addr]  <= lb_near[addr];
      lb_near[addr] <= pix_in;
    end
  end

  // same group, one and two columns back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CHAIN; k++) chain[k] <= '0;
    end else if (go) begin
      chain[0] <= cur_col;
      for (int k = 1; k < CHAIN; k++) chain[k] <= chain[k-1];
    end
  end

  assign cols[0] = left_zero ? '0 : chain[CHAIN-1];
  assign cols[1] = chain[GROUPS-1];
  assign cols[2] = cur_col;

  for (genvar ky = 0; ky < 3; ky++) begin : g_row
    for (genvar kx = 0; kx < 3; kx++) begin : g_col
      assign win[ky*3+kx] = cols[kx][(2-ky)*BEAT_W +: BEAT_W];
    end
  end

  p_lb_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lb_wr |-> (int'(addr) < DEPTH));
endmodule

// File: rtl/dwc_wmem.sv
module dwc_wmem import dwc_pkg::*; #(
  parameter int GROUPS = 2,
  parameter int N_IO   = 4,
  localparam int WORD_W = N_IO * WT_W,
  localparam int DEPTH  = TAPS * GROUPS,
  localparam int AW     = $clog2(DEPTH),
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [GRP_W-1:0]  rd_grp,
  output logic [WORD_W-1:0] rd_taps [TAPS]
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign rd_taps[t] = mem[AW'(int'(rd_grp) * TAPS + t)];
  end

  p_waddr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/dwc_pe.sv
module dwc_pe import dwc_pkg::*; #(
  parameter int N_IO  = 4,
  parameter int SHIFT = 4,
  localparam int BEAT_W = N_IO * ACT_W,
  localparam int WORD_W = N_IO * WT_W
) (
  input  logic [BEAT_W-1:0] win  [TAPS],
  input  logic [WORD_W-1:0] wts  [TAPS],
  output logic [BEAT_W-1:0] res
);
  for (genvar j = 0; j < N_IO; j++) begin : g_ch
    logic signed [SUM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int t = 0; t < TAPS; t++) begin
        acc = acc + SUM_W'(tap_product(win[t][j*ACT_W +: ACT_W],
                                       wts[t][j*WT_W +: WT_W]));
      end
    end
    assign res[j*ACT_W +: ACT_W] = requant(acc, SHIFT);
  end
endmodule

// File: rtl/dwconv3x3_stream.sv
module dwconv3x3_stream import dwc_pkg::*; #(
  parameter int IMG_W    = 8,
  parameter int IMG_H    = 6,
  parameter int CHANNELS = 8,
  parameter int N_IO     = 4,
  parameter int SHIFT    = 4,
  localparam int GROUPS  = CHANNELS / N_IO,
  localparam int BEAT_W  = N_IO * ACT_W,
  localparam int WORD_W  = N_IO * WT_W,
  localparam int WAW     = $clog2(TAPS * GROUPS),
  localparam int COL_W   = $clog2(IMG_W + 1),
  localparam int ROW_W   = $clog2(IMG_H + 1),
  localparam int GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wt_we,
  input  logic [WAW-1:0]    wt_addr,
  input  logic [WORD_W-1:0] wt_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_data
);
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic [GRP_W-1:0]  grp;
  logic              needs_in, emits, can_load, go;
  logic [BEAT_W-1:0] pix_in, result;
  logic [BEAT_W-1:0] win [TAPS];
  logic [WORD_W-1:0] wts [TAPS];

  // one slot per cycle at most; a stalled output freezes every slot
  assign can_load = !out_valid || out_ready;
  assign go       = can_load && (!needs_in || in_valid);
  assign in_ready = needs_in && can_load;
  assign pix_in   = needs_in ? in_data : '0;

  dwc_scan #(.IMG_W(IMG_W), .IMG_H(IMG_H), .GROUPS(GROUPS)) u_scan (
    .clk(clk), .rst_n(rst_n), .go(go), .col(col), .row(row), .grp(grp),
    .needs_in(needs_in), .emits(emits)
  );

  dwc_window #(.IMG_W(IMG_W), .GROUPS(GROUPS), .N_IO(N_IO)) u_window (
    .clk(clk), .rst_n(rst_n), .go(go), .col(col), .grp(grp),
    .top_zero(row < ROW_W'(2)), .mid_zero(row == '0),
    .left_zero(col < COL_W'(2)), .right_pad(col == COL_W'(IMG_W)),
    .pix_in(pix_in), .win(win)
  );

  dwc_wmem #(.GROUPS(GROUPS), .N_IO(N_IO)) u_wmem (
    .clk(clk), .rst_n(rst_n), .wr_en(wt_we), .wr_addr(wt_addr),
    .wr_word(wt_data), .rd_grp(grp), .rd_taps(wts)
  );

  dwc_pe #(.N_IO(N_IO), .SHIFT(SHIFT)) u_pe (
    .win(win), .wts(wts), .res(result)
  );

  // single output register; R8 reset state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (go && emits) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && emits) |=> out_valid);
endmodule

// File: tb/dwconv3x3_stream_tb.sv
`timescale 1ns/1ps
module dwconv3x3_stream_tb;
  localparam int W = 8, H = 6, CH = 8, NIO = 4, SH = 4;
  localparam int G = CH / NIO;
  localparam int TOTAL = W * H * G;
  localparam int BW = NIO * 8;
  localparam int WW = NIO * 5;
  localparam int WAW = $clog2(9 * G);
  localparam int FIRST_OUT = (W + 1) * G + 1;

  // stimulus table: mode, seed, ready gap, valid gap
  localparam int N_CASE = 5;
  localparam int T_MODE [N_CASE] = '{0, 1, 2, 3, 0};
  localparam int T_SEED [N_CASE] = '{1, 0, 0, 0, 7};
  localparam int T_RGAP [N_CASE] = '{0, 0, 3, 0, 4};
  localparam int T_VGAP [N_CASE] = '{0, 0, 0, 2, 5};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wt_we = 1'b0;
  logic [WAW-1:0] wt_addr = '0;
  logic [WW-1:0]  wt_data = '0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [BW-1:0] in_data = '0, out_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dwconv3x3_stream #(.IMG_W(W), .IMG_H(H), .CHANNELS(CH), .N_IO(NIO), .SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int pix(input int mode, input int seed, input int r, input int c, input int ch);
    case (mode)
      1: return 16;
      2: return 255;
      3: return 200;
      default: return (r * 37 + c * 11 + ch * 5 + seed * 13) % 256;
    endcase
  endfunction

  function automatic int wt(input int mode, input int seed, input int ch, input int tap);
    case (mode)
      1: return 1;
      2: return 15;
      3: return -16;
      default: return ((tap * 7 + ch * 3 + seed * 5) % 32) - 16;
    endcase
  endfunction

  function automatic int expect_px(input int mode, input int seed, input int r, input int c, input int ch);
    int s = 0;
    for (int dy = -1; dy <= 1; dy++)
      for (int dx = -1; dx <= 1; dx++)
        if (r + dy >= 0 && r + dy < H && c + dx >= 0 && c + dx < W)
          s += pix(mode, seed, r + dy, c + dx, ch) * wt(mode, seed, ch, (dy + 1) * 3 + dx + 1);
    s = s >>> SH;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic logic [BW-1:0] pack_in(input int mode, input int seed, input int k);
    logic [BW-1:0] d;
    int p = k / G, g = k % G;
    for (int j = 0; j < NIO; j++) d[j*8 +: 8] = 8'(pix(mode, seed, p / W, p % W, g * NIO + j));
    return d;
  endfunction

  function automatic logic [WW-1:0] pack_w(input int mode, input int seed, input int g, input int t);
    logic [WW-1:0] d;
    for (int j = 0; j < NIO; j++) d[j*5 +: 5] = 5'(wt(mode, seed, g * NIO + j, t));
    return d;
  endfunction

  task automatic run_frame(input int mode, input int seed, input int rgap, input int vgap, input int hold);
    int in_idx = 0, out_idx = 0, cyc = 0, hold_left = 0;
    bit seen = 0, prev_stall = 0, ifire, ofire;
    logic [BW-1:0] prev_data = '0;
    for (int g = 0; g < G; g++)
      for (int t = 0; t < 9; t++) begin
        @(negedge clk);
        wt_we = 1'b1; wt_addr = WAW'(g * 9 + t); wt_data = pack_w(mode, seed, g, t);
      end
    @(negedge clk);
    wt_we = 1'b0;
    while (out_idx < TOTAL && cyc < 20000) begin
      @(negedge clk);
      in_valid  = (in_idx < TOTAL) && (vgap == 0 || (cyc % vgap) != 0);
      in_data   = pack_in(mode, seed, in_idx);
      out_ready = (rgap == 0 || (cyc % rgap) != 0) && (hold_left == 0);
      #1;
      if (prev_stall) begin
        check(out_valid === 1'b1, "R5 valid held", int'(out_valid), 1);
        check(out_data === prev_data, "R5 data held", int'(out_data[7:0]), int'(prev_data[7:0]));
      end
      if (out_valid && !out_ready) check(in_ready === 1'b0, "R5 input blocked", int'(in_ready), 0);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (hold_left > 0) hold_left--;
      if (!seen && out_valid) begin
        seen = 1;
        hold_left = hold;
        check(in_idx == FIRST_OUT, "R6 first output latency (beats accepted)", in_idx, FIRST_OUT);
      end
      ifire = in_valid && in_ready;
      ofire = out_valid && out_ready;
      if (ofire) begin
        int p = out_idx / G, g = out_idx % G;
        for (int j = 0; j < NIO; j++) begin
          int e = expect_px(mode, seed, p / W, p % W, g * NIO + j);
          check(int'(out_data[j*8 +: 8]) == e,
                $sformatf("R1 R2 R3 R4 mode %0d pixel (%0d,%0d) ch %0d", mode, p / W, p % W, g * NIO + j),
                int'(out_data[j*8 +: 8]), e);
        end
      end
      @(posedge clk);
      if (ifire) in_idx++;
      if (ofire) out_idx++;
      cyc++;
    end
    check(in_idx == TOTAL && out_idx == TOTAL, "R1 beat count per frame", out_idx, TOTAL);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    check(out_valid === 1'b0, "R7 idle after frame, out_valid", int'(out_valid), 0);
    check(in_ready === 1'b1, "R7 ready for next frame, in_ready", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(out_valid === 1'b0, "R8 reset out_valid", int'(out_valid), 0);
    check(in_ready === 1'b1, "R8 reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;

    for (int i = 0; i < N_CASE; i++) run_frame(T_MODE[i], T_SEED[i], T_RGAP[i], T_VGAP[i], 0);

    // R5 directed: consumer holds off at the first output
    run_frame(0, 3, 0, 0, 6);

    // R8 directed: reset in the middle of a frame
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pack_in(0, 2, k); out_ready = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    #1;
    check(out_valid === 1'b0, "R8 mid-frame reset out_valid", int'(out_valid), 0);
    check(in_ready === 1'b1, "R8 mid-frame reset in_ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(0, 5, 2, 3, 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule